// File: doc/BRIEF.md
# Floating-Point Exception Classifier

This block sits beside a single-precision floating-point unit. For every finished instruction it takes the operation code, both operands and the result the arithmetic datapath produced, and works out which exception causes apply. The datapath itself is not part of the block; the result is only an input to be inspected.

Each 32-bit word is split into sign, 8-bit exponent and 23-bit mantissa, and sorted into zero, infinity, quiet NaN, signaling NaN or denormal. Per-operation rules then raise five raw cause flags. A priority encoder reduces them to one cause code. The flags, the code and a request strobe are registered, so they appear one clock after the instruction's valid cycle and last for that one cycle only.

Top module: `fpx_classifier`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, req_o, cause_o and flags_o are all zero.
- R2: req_o is high in the cycle after a clock edge at which valid_i was high and at least one flag applied. At every other time req_o is low and flags_o and cause_o are zero. Operands presented with valid_i low have no effect on the outputs.
- R3: Underflow, flags_o bit 0, is raised for add, subtract, multiply and divide when the result has exponent 0 and a nonzero mantissa.
- R4: Overflow, flags_o bit 1, is raised for add, subtract, multiply and divide when the result has exponent 255 and a nonzero mantissa. Either kind of NaN counts. An infinite result does not raise it.
- R5: Divide-by-zero, flags_o bit 2, is raised only for divide (a_i / b_i) when b_i is zero of either sign and a_i is not infinite.
- R6: Invalid operation, flags_o bit 3, is raised for every defined operation when either operand is a signaling NaN: exponent 255, nonzero mantissa, mantissa bit 22 clear. A quiet NaN (bit 22 set) alone does not raise it.
- R7: Invalid operation is also raised for these operand combinations:
  - add of two infinities with opposite signs;
  - subtract of two infinities with the same sign;
  - multiply of zero by infinity, in either order;
  - divide of zero by zero;
  - divide of infinity by infinity.
- R8: Denormalized operand, flags_o bit 4, is raised for every defined operation when either operand has exponent 0 and a nonzero mantissa.
- R9: cause_o encodes the highest-priority flag that applies. The order is invalid (1), divide-by-zero (2), denormal operand (3), overflow (4), underflow (5). The code is 0 when no flag applies.
- R10: Operation codes are add 0, subtract 1, multiply 2, divide 3 and compare 4. Compare raises only the R6 and R8 causes and ignores the result. Codes 5 to 7 raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and result are valid this cycle |
| op_i | input | 3 | Operation code (R10) |
| a_i | input | 32 | First operand (dividend for divide) |
| b_i | input | 32 | Second operand (divisor for divide) |
| res_i | input | 32 | Result produced by the datapath |
| req_o | output | 1 | Exception request, one cycle after valid_i |
| cause_o | output | 3 | Encoded highest-priority cause |
| flags_o | output | 5 | Raw cause flags: bit 0 underflow, bit 1 overflow, bit 2 divide-by-zero, bit 3 invalid, bit 4 denormal operand |

## Verification
The block has no state beyond one register stage. A wrong classification or a wrong priority therefore shows up on flags_o or cause_o in the cycle right after the offending instruction. A strobe that is stuck or leaks shows up on req_o in that same cycle. The sweep crosses signed zeros, infinities, both NaN kinds, denormals and normals for both operands, against six kinds of result and all eight operation codes. Every word-class pair therefore reaches the outputs within two clocks of being applied.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int FLAG_W = 5;
  localparam int OP_W   = 3;
  localparam int CAUSE_W = 3;

  localparam int FL_UNF = 0;
  localparam int FL_OVF = 1;
  localparam int FL_DVZ = 2;
  localparam int FL_INV = 3;
  localparam int FL_DEN = 4;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB = 3'd1;
  localparam logic [OP_W-1:0] OP_MUL = 3'd2;
  localparam logic [OP_W-1:0] OP_DIV = 3'd3;
  localparam logic [OP_W-1:0] OP_CMP = 3'd4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_INVALID   = 3'd1,
    CAUSE_DIVZERO   = 3'd2,
    CAUSE_DENORM    = 3'd3,
    CAUSE_OVERFLOW  = 3'd4,
    CAUSE_UNDERFLOW = 3'd5
  } cause_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic qnan;
    logic snan;
    logic denorm;
  } fp_class_t;
endpackage

// File: rtl/fpx_field_class.sv
module fpx_field_class
  import fpx_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] word_i,
  output fp_class_t      cls_o
);
  localparam int W = EW + MW + 1;

  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;
  logic exp_max, exp_min, man_nz;

  assign exp_f   = word_i[W-2 -: EW];
  assign man_f   = word_i[MW-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls_o        = '0;
    cls_o.sign   = word_i[W-1];
    cls_o.zero   = exp_min & ~man_nz;
    cls_o.denorm = exp_min & man_nz;
    cls_o.inf    = exp_max & ~man_nz;
    // top mantissa bit separates quiet from signaling
    cls_o.qnan   = exp_max & man_nz & man_f[MW-1];
    cls_o.snan   = exp_max & man_nz & ~man_f[MW-1];
  end
endmodule

// File: rtl/fpx_cause_rules.sv
module fpx_cause_rules
  import fpx_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  fp_class_t         a_i,
  input  fp_class_t         b_i,
  input  fp_class_t         r_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic known_op, arith_op, combo_bad;

  assign known_op = (op_i <= OP_CMP);
  assign arith_op = (op_i <= OP_DIV);

  always_comb begin
    combo_bad = 1'b0;
    case (op_i)
      OP_ADD:  combo_bad = a_i.inf & b_i.inf & (a_i.sign ^ b_i.sign);
      OP_SUB:  combo_bad = a_i.inf & b_i.inf & ~(a_i.sign ^ b_i.sign);
      OP_MUL:  combo_bad = (a_i.zero & b_i.inf) | (a_i.inf & b_i.zero);
      OP_DIV:  combo_bad = (a_i.zero & b_i.zero) | (a_i.inf & b_i.inf);
      default: combo_bad = 1'b0;
    endcase
  end

  always_comb begin
    flags_o         = '0;
    flags_o[FL_INV] = known_op & (a_i.snan | b_i.snan | combo_bad);
    flags_o[FL_DVZ] = (op_i == OP_DIV) & b_i.zero & ~a_i.inf;
    flags_o[FL_DEN] = known_op & (a_i.denorm | b_i.denorm);
    flags_o[FL_OVF] = arith_op & (r_i.qnan | r_i.snan);
    flags_o[FL_UNF] = arith_op & r_i.denorm;
  end
endmodule

// File: rtl/fpx_prio_enc.sv
module fpx_prio_enc
  import fpx_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output cause_e            cause_o,
  output logic              any_o
);
  assign any_o = |flags_i;

  always_comb begin
    if      (flags_i[FL_INV]) cause_o = CAUSE_INVALID;
    else if (flags_i[FL_DVZ]) cause_o = CAUSE_DIVZERO;
    else if (flags_i[FL_DEN]) cause_o = CAUSE_DENORM;
    else if (flags_i[FL_OVF]) cause_o = CAUSE_OVERFLOW;
    else if (flags_i[FL_UNF]) cause_o = CAUSE_UNDERFLOW;
    else                      cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/fpx_classifier.sv
module fpx_classifier
  import fpx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [WORD_W-1:0]  a_i,
  input  logic [WORD_W-1:0]  b_i,
  input  logic [WORD_W-1:0]  res_i,
  output logic               req_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [FLAG_W-1:0]  flags_o
);
  localparam int N_WORDS = 3;

  logic [N_WORDS-1:0][WORD_W-1:0] words;
  fp_class_t [N_WORDS-1:0]        cls;
  logic [FLAG_W-1:0]              raw_flags;
  cause_e                         enc_cause;
  logic                           any_cause;

  assign words = {res_i, b_i, a_i};

  for (genvar g = 0; g < N_WORDS; g++) begin : g_class
    fpx_field_class #(.EW(EXP_W), .MW(MAN_W)) u_class (
      .word_i (words[g]),
      .cls_o  (cls[g])
    );
  end

  fpx_cause_rules u_rules (
    .op_i    (op_i),
    .a_i     (cls[0]),
    .b_i     (cls[1]),
    .r_i     (cls[2]),
    .flags_o (raw_flags)
  );

  fpx_prio_enc u_enc (
    .flags_i (raw_flags),
    .cause_o (enc_cause),
    .any_o   (any_cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      cause_o <= CAUSE_NONE;
      flags_o <= '0;
    end else if (valid_i) begin
      req_o   <= any_cause;
      cause_o <= enc_cause;
      flags_o <= raw_flags;
    end else begin
      req_o   <= 1'b0;
      cause_o <= CAUSE_NONE;
      flags_o <= '0;
    end
  end

  assert_req_after_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(valid_i));
  assert_quiet_without_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (flags_o == '0 && cause_o == CAUSE_NONE));
  assert_req_has_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cause_o != CAUSE_NONE);
  assert_invalid_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FL_INV] |-> cause_o == CAUSE_INVALID);
  assert_divzero_only_div_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FL_DVZ] |-> $past(op_i) == OP_DIV);
  assert_cmp_no_result_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FL_OVF] | flags_o[FL_UNF]) |-> $past(op_i) <= OP_DIV);
endmodule

// File: tb/tb_fpx_classifier.sv
`timescale 1ns/1ps
module tb_fpx_classifier;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, res_i = '0;
  logic        req_o;
  logic [2:0]  cause_o;
  logic [4:0]  flags_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk_i = ~clk_i;

  fpx_classifier dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .res_i(res_i),
    .req_o(req_o), .cause_o(cause_o), .flags_o(flags_o)
  );

  function automatic logic [31:0] opnd(int i);
    case (i)
      0: return 32'h0000_0000; 1: return 32'h8000_0000;
      2: return 32'h7F80_0000; 3: return 32'hFF80_0000;
      4: return 32'h7FC0_0000; 5: return 32'h7F80_0001;
      6: return 32'hFFA0_0000; 7: return 32'h0000_0001;
      8: return 32'h3F80_0000; default: return 32'hC000_0000;
    endcase
  endfunction

  function automatic logic [31:0] rslt(int i);
    case (i)
      0: return 32'h3F80_0000; 1: return 32'h7FC0_0000;
      2: return 32'h007F_FFFF; 3: return 32'h7F80_0000;
      4: return 32'h0000_0000; default: return 32'h7F80_0001;
    endcase
  endfunction

  function automatic bit f_zero(logic [31:0] v); return v[30:23] == 0 && v[22:0] == 0; endfunction
  function automatic bit f_den (logic [31:0] v); return v[30:23] == 0 && v[22:0] != 0; endfunction
  function automatic bit f_inf (logic [31:0] v); return v[30:23] == 255 && v[22:0] == 0; endfunction
  function automatic bit f_nan (logic [31:0] v); return v[30:23] == 255 && v[22:0] != 0; endfunction
  function automatic bit f_snan(logic [31:0] v); return f_nan(v) && !v[22]; endfunction

  // returns {req, cause[2:0], flags[4:0]}
  function automatic logic [8:0] model(int op, logic [31:0] a, logic [31:0] b, logic [31:0] r);
    logic [4:0] fl = '0;
    logic [2:0] c;
    bit bad = 0;
    bit arith = (op <= 3);
    bit known = (op <= 4);
    if (op == 0) bad = f_inf(a) && f_inf(b) && (a[31] != b[31]);
    if (op == 1) bad = f_inf(a) && f_inf(b) && (a[31] == b[31]);
    if (op == 2) bad = (f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b));
    if (op == 3) bad = (f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b));
    fl[3] = known && (f_snan(a) || f_snan(b) || bad);
    fl[2] = (op == 3) && f_zero(b) && !f_inf(a);
    fl[4] = known && (f_den(a) || f_den(b));
    fl[1] = arith && f_nan(r);
    fl[0] = arith && f_den(r);
    c = fl[3] ? 3'd1 : fl[2] ? 3'd2 : fl[4] ? 3'd3 : fl[1] ? 3'd4 : fl[0] ? 3'd5 : 3'd0;
    return {|fl, c, fl};
  endfunction

  task automatic check(string tag, logic [8:0] exp);
    n_tests++;
    if ({req_o, cause_o, flags_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: req/cause/flags got %b/%0d/%b expected %b/%0d/%b",
               tag, req_o, cause_o, flags_o, exp[8], exp[7:5], exp[4:0]);
    end
  endtask

  function automatic string tag_of(int op, logic [8:0] e);
    if (op > 3 && e[8]) return "R10";
    if (op > 4)        return "R10";
    case (e[7:5])
      3'd1: return "R6/R7";
      3'd2: return "R5";
      3'd3: return "R8";
      3'd4: return "R4";
      3'd5: return "R3";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: drive an invalid case during reset
    valid_i = 1; op_i = 3'd3; a_i = 32'h0; b_i = 32'h0; res_i = 32'h7FC0_0000;
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 9'd0);
    valid_i = 0;
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 after release", 9'd0);

    // R2: operands with valid low have no effect
    op_i = 3'd0; a_i = 32'h7F80_0001; b_i = 32'h0000_0001; res_i = 32'h7FC0_0000;
    @(negedge clk_i);
    check("R2 valid low", 9'd0);

    // R2: strobe lasts a single cycle
    valid_i = 1;
    @(negedge clk_i);
    valid_i = 0;
    check("R2 strobe", model(0, a_i, b_i, res_i));
    @(negedge clk_i);
    check("R2 strobe drop", 9'd0);

    for (int op = 0; op < 8; op++)
      for (int ia = 0; ia < 10; ia++)
        for (int ib = 0; ib < 10; ib++)
          for (int ir = 0; ir < 6; ir++) begin
            logic [8:0] e;
            valid_i = 1; op_i = op[2:0];
            a_i = opnd(ia); b_i = opnd(ib); res_i = rslt(ir);
            e = model(op, a_i, b_i, res_i);
            @(negedge clk_i);
            check(tag_of(op, e), e);
          end

    // R9 directed: divide-by-zero beats denormal operand and overflow
    op_i = 3'd3; a_i = 32'h0000_0001; b_i = 32'h8000_0000; res_i = 32'h7FC0_0000;
    @(negedge clk_i);
    check("R9 dvz over den", {1'b1, 3'd2, 5'b10110});
    // R7 directed: 0 * -inf
    op_i = 3'd2; a_i = 32'h0; b_i = 32'hFF80_0000; res_i = 32'h3F80_0000;
    @(negedge clk_i);
    check("R7 zero times inf", {1'b1, 3'd1, 5'b01000});
    // R4 directed: infinite result is not overflow
    op_i = 3'd0; a_i = 32'h3F80_0000; b_i = 32'h3F80_0000; res_i = 32'h7F80_0000;
    @(negedge clk_i);
    check("R4 inf result", 9'd0);
    valid_i = 0;
    @(negedge clk_i);
    check("R2 idle end", 9'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule